// File: doc/BRIEF.md
# Pointer-Routed Stack Unit

This block carries out stack operations (push, pop, call, return) through one of two independent stack pointers, A and B. For every stack operation it looks at the word address the operation will touch and picks where the entry lives. Addresses from 0x200 to 0x3FF go to a private 512-word by 32-bit RAM inside the unit, and every other address goes out on a request/acknowledge port to shared main memory. Only the pointer value makes this choice. No program counter and no separate opcode set is involved, so software moves a stack into or out of the local RAM just by loading the pointer.

Plain loads and stores of any size pass straight through to main memory with their address and size unchanged. They reach main memory even when the address falls in the local window. A local access finishes in one cycle. A main-memory access holds the unit busy until the acknowledge arrives, and a command offered while the unit is busy is not taken.

Command encoding on `cmd_op`: 0 no-op, 1 push, 2 pop, 3 call, 4 return, 5 load, 6 store, 7 set pointer. `cmd_sel` = 0 selects pointer A and 1 selects pointer B. A command is accepted on a rising edge where `cmd_valid` is high and `busy` is low.

The controller has two states:
- IDLE: accepts commands.
- MEM_WAIT: holds a main-memory request.

It has three transitions:
- accept-local: IDLE to IDLE, for a local stack access or a set-pointer command.
- accept-mem: IDLE to MEM_WAIT, for a stack access outside the window, a load or a store.
- acknowledged: MEM_WAIT to IDLE, when `mm_ack` is high.

Top module: `stk_unit`

## Requirements
- R1: After reset both pointers read 0, and `busy`, `mm_req` and `rsp_valid` are low.
- R2: Each stack operation has a target word address. For push and call it is the selected pointer; for pop and return it is the pointer minus 1. A target from 0x200 to 0x3FF inclusive uses the local RAM and raises no `mm_req`. Any other target produces exactly one main-memory transaction with `mm_addr` equal to the target and `mm_size` = 2'b10 (long).
- R3: A local access addresses the RAM with the low 9 bits of the target, and this RAM is shared by both pointers. It never asserts `busy`. A local pop or return raises `rsp_valid` in the cycle right after acceptance.
- R4: Push (op 1) writes `cmd_data` at the target and then leaves the pointer one higher (post-increment).
- R5: Pop (op 2) lowers the pointer by one and returns the full 32-bit entry stored at the new value on `rsp_data` (pre-decrement, last in first out).
- R6: Call (op 3) pushes `cmd_data` as the return address through the selected pointer. Return (op 4) pops it back through the same pointer and presents it on `rsp_data`. Both follow the same routing rule as push and pop.
- R7: Load (op 5) and store (op 6) always go to main memory with `mm_addr` = `cmd_addr` and `mm_size` = `cmd_size`, including addresses 0x200 to 0x3FF. They leave both pointers and the local RAM unchanged, and a load returns `mm_rdata` on `rsp_data`.
- R8: A main-memory access holds `busy` and `mm_req` high, with a stable address, write data and direction, from the cycle after acceptance until the cycle `mm_ack` is seen. A command offered while `busy` is high has no effect.
- R9: Set pointer (op 7) loads `cmd_data[19:0]` into the selected pointer only. Both pointers can always be read on `ptr_a` and `ptr_b`. An operation through one pointer never changes the other.
- R10: A pointer that crosses either edge of the window during push or pop is not clamped. The next operation is routed by the pointer's new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Operation code |
| cmd_sel | input | 1 | Pointer select: 0 = A, 1 = B |
| cmd_data | input | 32 | Push value, return address, store data or new pointer value |
| cmd_addr | input | 20 | Load/store word address |
| cmd_size | input | 2 | Load/store access size |
| busy | output | 1 | Main-memory access in progress; commands are not taken |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds popped or loaded data |
| rsp_data | output | 32 | Popped entry, return address or loaded data |
| ptr_a | output | 20 | Current value of pointer A |
| ptr_b | output | 20 | Current value of pointer B |
| mm_req | output | 1 | Main-memory request |
| mm_we | output | 1 | Main-memory write enable |
| mm_addr | output | 20 | Main-memory word address |
| mm_wdata | output | 32 | Main-memory write data |
| mm_size | output | 2 | Main-memory access size |
| mm_ack | input | 1 | Main-memory acknowledge |
| mm_rdata | input | 32 | Main-memory read data |

## Verification
The hardest case to reach from the ports is a stack that straddles the window edge. One entry sits in the local RAM and the next sits in main memory, and the single pre-decrement of a pop carries the access from one store to the other. The stimulus places a pointer exactly on the edge (0x3FF, then 0x200) with a set-pointer command. It pushes and pops across the edge while counting main-memory transactions, and it preloads the main-memory model so that a value read from the wrong store is visible on `rsp_data`. A command offered in the middle of a stalled main-memory access is also driven, to show that it leaves the pointers unchanged.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4,
        OP_LOAD  = 3'd5,
        OP_STORE = 3'd6,
        OP_SETP  = 3'd7
    } stk_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_MEM_WAIT
    } stk_state_e;

    localparam logic [1:0] SZ_LONG = 2'b10;

endpackage

// File: rtl/stk_route.sv
module stk_route #(
    parameter int PTR_W = 20,
    parameter int LR_AW = 9
) (
    input  logic [PTR_W-1:0] tgt,
    output logic             is_local
);
    localparam int HI_W = PTR_W - LR_AW;
    localparam logic [HI_W-1:0] WIN_TAG = HI_W'(1);

    // window is [2**LR_AW, 2**(LR_AW+1)-1]: upper bits equal 1
    assign is_local = (tgt[PTR_W-1:LR_AW] == WIN_TAG);
endmodule

// File: rtl/stk_ptr_file.sv
module stk_ptr_file #(
    parameter int PTR_W = 20,
    parameter int NPTR  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inc_en,
    input  logic                    dec_en,
    input  logic                    ld_en,
    input  logic [$clog2(NPTR)-1:0] sel,
    input  logic [PTR_W-1:0]        ld_val,
    output logic [PTR_W-1:0]        ptr [NPTR]
);
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic [PTR_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (sel == g) begin
                if (ld_en)       q <= ld_val;
                else if (inc_en) q <= q + 1'b1;
                else if (dec_en) q <= q - 1'b1;
            end
        end
        assign ptr[g] = q;
    end
endmodule

// File: rtl/stk_lram.sv
module stk_lram #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/stk_unit.sv
module stk_unit
    import stk_pkg::*;
#(
    parameter int PTR_W = 20,
    parameter int DW    = 32,
    parameter int LR_AW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_sel,
    input  logic [DW-1:0]    cmd_data,
    input  logic [PTR_W-1:0] cmd_addr,
    input  logic [1:0]       cmd_size,
    output logic             busy,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic [PTR_W-1:0] ptr_a,
    output logic [PTR_W-1:0] ptr_b,
    output logic             mm_req,
    output logic             mm_we,
    output logic [PTR_W-1:0] mm_addr,
    output logic [DW-1:0]    mm_wdata,
    output logic [1:0]       mm_size,
    input  logic             mm_ack,
    input  logic [DW-1:0]    mm_rdata
);
    stk_state_e state_q, state_d;
    stk_op_e    op;

    logic             accept, is_push, is_pop, stack_op, ls_op;
    logic             tgt_local, go_local, go_mem;
    logic [PTR_W-1:0] cur_ptr, tgt;
    logic [PTR_W-1:0] ptrs [2];

    logic [PTR_W-1:0] mreq_addr;
    logic [DW-1:0]    mreq_wdata;
    logic             mreq_we, mreq_rd;
    logic [1:0]       mreq_size;

    logic             rsp_v_q, src_local_q;
    logic [DW-1:0]    mm_data_q, lram_rd;

    // command decode
    assign op       = stk_op_e'(cmd_op);
    assign accept   = cmd_valid && (state_q == ST_IDLE);
    assign is_push  = (op == OP_PUSH) || (op == OP_CALL);
    assign is_pop   = (op == OP_POP)  || (op == OP_RET);
    assign stack_op = is_push || is_pop;
    assign ls_op    = (op == OP_LOAD) || (op == OP_STORE);
    assign cur_ptr  = cmd_sel ? ptrs[1] : ptrs[0];
    assign tgt      = is_pop ? cur_ptr - 1'b1 : cur_ptr;
    assign go_local = accept && stack_op && tgt_local;
    assign go_mem   = accept && ((stack_op && !tgt_local) || ls_op);

    stk_route #(.PTR_W(PTR_W), .LR_AW(LR_AW)) u_route (
        .tgt      (tgt),
        .is_local (tgt_local)
    );

    stk_ptr_file #(.PTR_W(PTR_W), .NPTR(2)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_en (accept && is_push),
        .dec_en (accept && is_pop),
        .ld_en  (accept && (op == OP_SETP)),
        .sel    (cmd_sel),
        .ld_val (cmd_data[PTR_W-1:0]),
        .ptr    (ptrs)
    );

    stk_lram #(.AW(LR_AW), .DW(DW)) u_lram (
        .clk   (clk),
        .we    (go_local && is_push),
        .waddr (tgt[LR_AW-1:0]),
        .wdata (cmd_data),
        .re    (go_local && is_pop),
        .raddr (tgt[LR_AW-1:0]),
        .rdata (lram_rd)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: accept-local / accept-mem / acknowledged
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (go_mem) state_d = ST_MEM_WAIT;
            ST_MEM_WAIT: if (mm_ack) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // captured main-memory request and response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreq_addr   <= '0;
            mreq_wdata  <= '0;
            mreq_we     <= 1'b0;
            mreq_rd     <= 1'b0;
            mreq_size   <= SZ_LONG;
            rsp_v_q     <= 1'b0;
            src_local_q <= 1'b0;
            mm_data_q   <= '0;
        end else begin
            rsp_v_q <= 1'b0;
            if (go_mem) begin
                mreq_addr  <= stack_op ? tgt : cmd_addr;
                mreq_wdata <= cmd_data;
                mreq_we    <= is_push || (op == OP_STORE);
                mreq_rd    <= is_pop  || (op == OP_LOAD);
                mreq_size  <= stack_op ? SZ_LONG : cmd_size;
            end
            if (go_local && is_pop) begin
                rsp_v_q     <= 1'b1;
                src_local_q <= 1'b1;
            end else if (state_q == ST_MEM_WAIT && mm_ack && mreq_rd) begin
                rsp_v_q     <= 1'b1;
                src_local_q <= 1'b0;
                mm_data_q   <= mm_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_MEM_WAIT);
        mm_req    = (state_q == ST_MEM_WAIT);
        mm_we     = mreq_we;
        mm_addr   = mreq_addr;
        mm_wdata  = mreq_wdata;
        mm_size   = mreq_size;
        rsp_valid = rsp_v_q;
        rsp_data  = src_local_q ? lram_rd : mm_data_q;
        ptr_a     = ptrs[0];
        ptr_b     = ptrs[1];
    end
endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk #(
    parameter int PTR_W = 20,
    parameter int DW    = 32,
    parameter int LR_AW = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             cmd_sel,
    input logic [DW-1:0]    cmd_data,
    input logic [PTR_W-1:0] cmd_addr,
    input logic [1:0]       cmd_size,
    input logic             busy,
    input logic             rsp_valid,
    input logic [DW-1:0]    rsp_data,
    input logic [PTR_W-1:0] ptr_a,
    input logic [PTR_W-1:0] ptr_b,
    input logic             mm_req,
    input logic             mm_we,
    input logic [PTR_W-1:0] mm_addr,
    input logic [DW-1:0]    mm_wdata,
    input logic [1:0]       mm_size,
    input logic             mm_ack,
    input logic [DW-1:0]    mm_rdata
);
    localparam int HI_W = PTR_W - LR_AW;
    localparam logic [HI_W-1:0] WIN = HI_W'(1);

    logic             take, push_like, pop_like;
    logic [PTR_W-1:0] sp, where;

    assign take      = cmd_valid && !busy;
    assign push_like = (cmd_op == 3'd1) || (cmd_op == 3'd3);
    assign pop_like  = (cmd_op == 3'd2) || (cmd_op == 3'd4);
    assign sp        = cmd_sel ? ptr_b : ptr_a;
    assign where     = pop_like ? sp - 1'b1 : sp;

    a_r2_local_no_mm: assert property (@(posedge clk) disable iff (!rst_n)
        take && (push_like || pop_like) && (where[PTR_W-1:LR_AW] == WIN) |=> !mm_req);

    a_r3_local_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        take && pop_like && (where[PTR_W-1:LR_AW] == WIN) |=> rsp_valid);

    a_r4_push_inc_a: assert property (@(posedge clk) disable iff (!rst_n)
        take && push_like && !cmd_sel |=> ptr_a == $past(ptr_a) + 1'b1);

    a_r5_pop_dec_b: assert property (@(posedge clk) disable iff (!rst_n)
        take && pop_like && cmd_sel |=> ptr_b == $past(ptr_b) - 1'b1);

    a_r7_load_to_mm: assert property (@(posedge clk) disable iff (!rst_n)
        take && (cmd_op == 3'd5) |=> mm_req && !mm_we && (mm_addr == $past(cmd_addr)));

    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mm_req && !mm_ack |=> mm_req && $stable(mm_addr) && $stable(mm_wdata) && $stable(mm_we));

    a_r8_busy_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_a) && $stable(ptr_b));

    a_r9_a_op_keeps_b: assert property (@(posedge clk) disable iff (!rst_n)
        take && !cmd_sel |=> $stable(ptr_b));
endmodule

bind stk_unit stk_unit_chk #(.PTR_W(PTR_W), .DW(DW), .LR_AW(LR_AW)) u_chk (.*);

// File: tb/test_stk_unit.sv
module test_stk_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic        cmd_sel = 1'b0;
    logic [31:0] cmd_data = '0;
    logic [19:0] cmd_addr = '0;
    logic [1:0]  cmd_size = '0;
    logic        busy, rsp_valid, mm_req, mm_we;
    logic [31:0] rsp_data, mm_wdata;
    logic [19:0] ptr_a, ptr_b, mm_addr;
    logic [1:0]  mm_size;
    logic        mm_ack = 1'b0;
    logic [31:0] mm_rdata = '0;

    int checks = 0;
    int errors = 0;

    // main memory model
    logic [31:0] mem [1024];
    int          mm_cnt = 0;
    int          lat_cnt = 0;
    logic [19:0] last_addr;
    logic [1:0]  last_size;
    logic        last_we;

    always #2 clk = ~clk;

    stk_unit i_stk_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sel(cmd_sel), .cmd_data(cmd_data), .cmd_addr(cmd_addr),
        .cmd_size(cmd_size), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .ptr_a(ptr_a), .ptr_b(ptr_b), .mm_req(mm_req),
        .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
        .mm_size(mm_size), .mm_ack(mm_ack), .mm_rdata(mm_rdata)
    );

    always @(posedge clk) begin
        if (mm_req && !mm_ack) begin
            if (lat_cnt == 1) begin
                mm_ack    <= 1'b1;
                lat_cnt   <= 0;
                mm_rdata  <= mem[mm_addr[9:0]];
                if (mm_we) mem[mm_addr[9:0]] <= mm_wdata;
                mm_cnt    <= mm_cnt + 1;
                last_addr <= mm_addr;
                last_size <= mm_size;
                last_we   <= mm_we;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mm_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one command, wait for completion; returns response and busy cycles
    task automatic issue(input logic [2:0] op, input logic sel, input logic [31:0] data,
                         input logic [19:0] addr, input logic [1:0] size,
                         output logic got, output logic [31:0] rd, output int bcyc);
        got = 1'b0; rd = '0; bcyc = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel;
        cmd_data = data; cmd_addr = addr; cmd_size = size;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        for (int i = 0; i < 20; i++) begin
            if (rsp_valid) begin got = 1'b1; rd = rsp_data; end
            if (!busy) break;
            bcyc++;
            @(negedge clk);
        end
    endtask

    task automatic setp(input logic sel, input logic [19:0] v);
        logic g; logic [31:0] d; int b;
        issue(3'd7, sel, {12'd0, v}, '0, '0, g, d, b);
    endtask

    task automatic t_reset;
        chk("R1 ptr_a", {12'd0, ptr_a}, 32'd0);
        chk("R1 ptr_b", {12'd0, ptr_b}, 32'd0);
        chk("R1 busy/mm_req/rsp_valid", {29'd0, busy, mm_req, rsp_valid}, 32'd0);
    endtask

    task automatic t_local_lifo;
        logic g; logic [31:0] d; int b; int m0;
        m0 = mm_cnt;
        setp(1'b0, 20'h200);
        chk("R9 set pointer A", {12'd0, ptr_a}, 32'h200);
        issue(3'd1, 1'b0, 32'hDEADBEEF, '0, '0, g, d, b);
        chk("R3 local push never busy", b, 0);
        issue(3'd1, 1'b0, 32'h12345678, '0, '0, g, d, b);
        chk("R4 post-increment", {12'd0, ptr_a}, 32'h202);
        issue(3'd2, 1'b0, 0, '0, '0, g, d, b);
        chk("R5 pop newest", d, 32'h12345678);
        chk("R3 local pop response", {31'd0, g}, 32'd1);
        chk("R5 pre-decrement", {12'd0, ptr_a}, 32'h201);
        issue(3'd2, 1'b0, 0, '0, '0, g, d, b);
        chk("R5 pop older full width", d, 32'hDEADBEEF);
        chk("R2 local ops no mm transaction", mm_cnt - m0, 0);
    endtask

    task automatic t_shared_ram;
        logic g; logic [31:0] d; int b;
        setp(1'b0, 20'h205);
        issue(3'd1, 1'b0, 32'h0BADCAFE, '0, '0, g, d, b);
        setp(1'b1, 20'h206);
        chk("R9 A untouched by B load", {12'd0, ptr_a}, 32'h206);
        issue(3'd2, 1'b1, 0, '0, '0, g, d, b);
        chk("R3 RAM shared, low 9 bits", d, 32'h0BADCAFE);
        chk("R9 B popped, A unchanged", {12'd0, ptr_a}, 32'h206);
    endtask

    task automatic t_mem_stack;
        logic g; logic [31:0] d; int b; int m0;
        m0 = mm_cnt;
        setp(1'b0, 20'h010);
        issue(3'd1, 1'b0, 32'hCAFEF00D, '0, '0, g, d, b);
        chk("R2 one mm transaction", mm_cnt - m0, 1);
        chk("R2 mm addr = pointer", {12'd0, last_addr}, 32'h10);
        chk("R2 mm size long, write", {29'd0, last_size, last_we}, {29'd0, 2'b10, 1'b1});
        chk("R2 mm holds data", mem[16], 32'hCAFEF00D);
        chk("R8 busy while waiting", {31'd0, b > 0}, 32'd1);
        issue(3'd2, 1'b0, 0, '0, '0, g, d, b);
        chk("R8 popped mm data", d, 32'hCAFEF00D);
        chk("R5 mm pop address", {12'd0, last_addr}, 32'h10);
    endtask

    task automatic t_boundary;
        logic g; logic [31:0] d; int b; int m0;
        setp(1'b0, 20'h3FF);
        m0 = mm_cnt;
        issue(3'd1, 1'b0, 32'h11110001, '0, '0, g, d, b);
        chk("R10 last local slot", mm_cnt - m0, 0);
        chk("R10 no clamp", {12'd0, ptr_a}, 32'h400);
        issue(3'd1, 1'b0, 32'h22220002, '0, '0, g, d, b);
        chk("R10 next push to mm", mm_cnt - m0, 1);
        chk("R10 mm address 0x400", mem[10'h000 + 10'd0 + 10'h3FF + 10'h001], 32'h22220002);
        issue(3'd2, 1'b0, 0, '0, '0, g, d, b);
        chk("R10 pop from mm", d, 32'h22220002);
        issue(3'd2, 1'b0, 0, '0, '0, g, d, b);
        chk("R10 pop back into local", d, 32'h11110001);
        chk("R10 local pop no mm", mm_cnt - m0, 2);
        setp(1'b0, 20'h200);
        issue(3'd2, 1'b0, 0, '0, '0, g, d, b);
        chk("R2 pop below window uses mm", d, 32'hA5A5A5A5);
        chk("R2 mm addr 0x1FF", {12'd0, last_addr}, 32'h1FF);
        chk("R10 pointer left window", {12'd0, ptr_a}, 32'h1FF);
    endtask

    task automatic t_call_ret;
        logic g; logic [31:0] d; int b; int m0;
        setp(1'b1, 20'h300);
        m0 = mm_cnt;
        issue(3'd3, 1'b1, 32'h000ABCDE, '0, '0, g, d, b);
        chk("R6 call increments B", {12'd0, ptr_b}, 32'h301);
        issue(3'd4, 1'b1, 0, '0, '0, g, d, b);
        chk("R6 ret local address", d, 32'h000ABCDE);
        chk("R6 local call/ret no mm", mm_cnt - m0, 0);
        setp(1'b1, 20'h050);
        issue(3'd3, 1'b1, 32'h00012340, '0, '0, g, d, b);
        chk("R6 call to mm", mem[80], 32'h00012340);
        issue(3'd4, 1'b1, 0, '0, '0, g, d, b);
        chk("R6 ret from mm", d, 32'h00012340);
        chk("R6 ret restores B", {12'd0, ptr_b}, 32'h50);
    endtask

    task automatic t_load_store;
        logic g; logic [31:0] d; int b; int m0;
        setp(1'b0, 20'h250);
        issue(3'd1, 1'b0, 32'h11112222, '0, '0, g, d, b);
        m0 = mm_cnt;
        issue(3'd6, 1'b0, 32'h33334444, 20'h250, 2'b00, g, d, b);
        chk("R7 store goes to mm", mm_cnt - m0, 1);
        chk("R7 store addr/size", {10'd0, last_size, last_addr}, {10'd0, 2'b00, 20'h250});
        chk("R7 store leaves pointer", {12'd0, ptr_a}, 32'h251);
        issue(3'd5, 1'b0, 0, 20'h250, 2'b01, g, d, b);
        chk("R7 load returns mm data", d, 32'h33334444);
        chk("R7 load size passed", {30'd0, last_size}, 32'd1);
        issue(3'd2, 1'b0, 0, '0, '0, g, d, b);
        chk("R7 local RAM untouched by store", d, 32'h11112222);
    endtask

    task automatic t_busy_ignore;
        setp(1'b0, 20'h020);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_sel = 1'b0; cmd_data = 32'h5;
        @(negedge clk);
        cmd_op = 3'd7; cmd_data = 32'h333;   // offered while busy
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        while (busy) @(negedge clk);
        chk("R8 command while busy ignored", {12'd0, ptr_a}, 32'h21);
        chk("R8 stalled push stored", mem[32], 32'h5);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5A5A5;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_local_lifo();
        t_shared_ram();
        t_mem_stack();
        t_boundary();
        t_call_ret();
        t_load_store();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule